// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial memory holding 2048 bytes. It samples the serial clock and data lines with the system clock and passes each through a short synchroniser. It finds start and stop conditions and bus-clock edges by comparing each sample with the one before it. It pulls the data line low through an open-drain enable output. A master on the bus selects the device with an address byte, then writes single bytes or pages, or reads from the current pointer, from a chosen address, or as a sequential stream.

A stop that follows at least one written data byte starts a timed busy interval, counted in system clocks. While that interval runs, the slave acknowledges nothing, not even its own address. A master can therefore poll with address bytes until one is acknowledged. A write-protect input lets the bus traffic complete as normal but leaves the storage unchanged.

Top module: `ee2w_slave`

## Requirements
- R1: After reset, and whenever the engine is idle, `sda_oe` is 0 (the data line is released).
- R2: The address byte is received MSB first. It matches only when bit 7 is 1 and bits 6, 5, 4 equal `sel_pins[2]`, the inverse of `sel_pins[1]`, and `sel_pins[0]`. On a match the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: In a write (address bit 0 = 0), address bits 3..1 form word-address bits 10..8 and the next byte forms bits 7..0. Every word-address and data byte is acknowledged, and each data byte is stored at the current pointer.
- R4: After each stored byte, only the low 4 pointer bits increment. They wrap from 15 to 0 inside the same 16-byte page, so bits 10..4 stay fixed.
- R5: A stop after at least one data byte starts a busy interval of BUSY_CYCLES clocks. During it no address byte is acknowledged. After it ends, the device address is acknowledged again.
- R6: A stop before any data byte (for example after a word-address-only header) starts no busy interval.
- R7: In a read (address bit 0 = 1), address bits 3..1 replace pointer bits 10..8. The byte at the pointer is sent MSB first. After each byte sent, the pointer advances by one. A random read is a write header followed by a repeated start and a read address.
- R8: While the master acknowledges, the slave sends consecutive bytes, and the pointer wraps from 2047 to 0. A master no-acknowledge ends the read, and SDA stays released.
- R9: With `wp_i` high, data bytes are still acknowledged but the stored contents do not change.
- R10: A start at any point aborts the transfer in progress. A partly received byte is discarded, and a new address phase begins.
- R11: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line sample |
| sda_i | input | 1 | Serial data line sample (wired bus level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| sel_pins | input | 3 | Chip-select straps |
| wp_i | input | 1 | Write protect, 1 blocks storage updates |

## Verification
The bench writes six bytes past the end of a page and reads all of them back. A design that carried into bit 4 would place the last two bytes on the next page. It polls right after a write stop and again after the busy interval. A timer started by a header-only stop, or one that never ran, would show up in the acknowledge it returns. A sequential read across address 2047 catches a pointer that saturates or wraps only inside a page. A start placed in the middle of a data byte, followed by a current-address read, exposes a design that stores the partial byte or loses the pointer.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam int BYTE_BITS = 8;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] pins);
        return b[7] && (b[6:4] == {pins[2], ~pins[1], pins[0]});
    endfunction

endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync
    import ee2w_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] line_now;
    logic [1:0] line_prev;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain        <= '1;
                    line_prev[g] <= 1'b1;
                end else begin
                    chain        <= {chain[STAGES-2:0], raw[g]};
                    line_prev[g] <= chain[STAGES-1];
                end
            end
            assign line_now[g] = chain[STAGES-1];
        end
    endgenerate

    always_comb begin
        ev.scl      = line_now[1];
        ev.sda      = line_now[0];
        ev.scl_rise = line_now[1] & ~line_prev[1];
        ev.scl_fall = ~line_now[1] & line_prev[1];
        ev.start    = line_now[1] & line_prev[1] & line_prev[0] & ~line_now[0];
        ev.stop     = line_now[1] & line_prev[1] & ~line_prev[0] & line_now[0];
    end

    p_start_stop_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));

endmodule

// File: rtl/ee2w_busy.sv
module ee2w_busy #(
    parameter int CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (go)
            left <= CW'(CYCLES);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);

    p_busy_countdown_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !go) |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/ee2w_mem.sv
module ee2w_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int AW          = 11,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] sel_pins,
    input  logic       wp_i
);
    localparam int BLK_W = AW - BYTE_BITS;

    bus_ev_t         ev;
    ee_state_e       st, nxt_st;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [AW-1:0]   ptr;
    logic            got_data;
    logic            mack;
    logic            busy_go;
    logic            busy;
    logic            mem_we;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;
    logic [7:0]      rd_data;

    ee2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    ee2w_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst(rst), .go(busy_go), .busy(busy)
    );

    ee2w_mem #(.AW(AW), .DW(8)) u_mem (
        .clk(clk), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(ptr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            nxt_st   <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            got_data <= 1'b0;
            mack     <= 1'b0;
            busy_go  <= 1'b0;
            mem_we   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            mem_we  <= 1'b0;
            busy_go <= 1'b0;
            if (ev.start) begin
                st       <= ST_DEV;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                got_data <= 1'b0;
            end else if (ev.stop) begin
                if (st == ST_WDAT && got_data) busy_go <= 1'b1;
                st       <= ST_IDLE;
                sda_oe   <= 1'b0;
                got_data <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (ev.scl_rise && cnt < 4'd8) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            if (st == ST_DEV) begin
                                if (!busy && dev_match(shreg, sel_pins)) begin
                                    sda_oe              <= 1'b1;
                                    ptr[AW-1:BYTE_BITS] <= shreg[BLK_W:1];
                                    nxt_st              <= shreg[0] ? ST_RDAT : ST_WADR;
                                    st                  <= ST_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_WADR) begin
                                sda_oe                <= 1'b1;
                                ptr[BYTE_BITS-1:0]    <= shreg;
                                nxt_st                <= ST_WDAT;
                                st                    <= ST_ACK;
                            end else begin
                                sda_oe   <= 1'b1;
                                mem_we   <= !wp_i;
                                wr_addr  <= ptr;
                                wr_data  <= shreg;
                                ptr      <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                got_data <= 1'b1;
                                nxt_st   <= ST_WDAT;
                                st       <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            st  <= nxt_st;
                            if (nxt_st == ST_RDAT) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (ev.scl_rise && cnt < 4'd8) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                            ptr  <= ptr + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                                st     <= ST_RDAT;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    p_deaf_when_busy_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (st == ST_IDLE || st == ST_DEV));

    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev.stop, 2));

    p_page_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && $past(st) == ST_WDAT) |->
            (ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W])));

endmodule

// File: tb/tb_ee2w_slave.sv
module tb_ee2w_slave;
    localparam int BUSY = 600;
    localparam int H    = 8;
    localparam int Q    = 2;
    localparam logic [2:0] SEL = 3'b101;

    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {11'h055, 8'h77}, {11'h123, 8'h11}, {11'h400, 8'h5A},
        {11'h7FF, 8'hC3}, {11'h000, 8'h3C}, {11'h2B6, 8'h96}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    int viol  = 0;
    logic prev_oe = 1'b0;
    logic done = 1'b0;
    logic [7:0] rbuf [8];

    always #5 clk = ~clk;

    ee2w_slave #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sel_pins(SEL), .wp_i(wp)
    );

    always @(negedge clk) begin
        if (!rst && (sda_oe !== prev_oe) && scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic [2:0] blk, input logic rw);
        return {1'b1, SEL[2], ~SEL[1], SEL[0], blk, rw};
    endfunction

    task automatic bus_start();
        scl = 1'b0; clks(Q); sda_m = 1'b1; clks(H);
        scl = 1'b1; clks(H); sda_m = 1'b0; clks(H);
        scl = 1'b0; clks(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; clks(Q); sda_m = 1'b0; clks(H);
        scl = 1'b1; clks(H); sda_m = 1'b1; clks(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl = 1'b0; clks(Q); sda_m = b[i]; clks(H);
            scl = 1'b1; clks(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        scl = 1'b0; clks(Q); sda_m = 1'b1; clks(H);
        scl = 1'b1; clks(H / 2); ack = ~sda_line; clks(H / 2);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; clks(Q); sda_m = 1'b1; clks(H);
            scl = 1'b1; clks(H / 2); b[i] = sda_line; clks(H / 2);
        end
        scl = 1'b0; clks(Q); sda_m = ~mack; clks(H);
        scl = 1'b1; clks(H);
    endtask

    task automatic write_hdr(input logic [10:0] a, output logic ok);
        logic a1, a2;
        bus_start();
        send_byte(dev(a[10:8], 1'b0), a1);
        send_byte(a[7:0], a2);
        ok = a1 & a2;
    endtask

    task automatic rd_seq(input logic [10:0] a, input int n, output logic ok);
        logic h, a3;
        logic [7:0] b;
        write_hdr(a, h);
        bus_start();
        send_byte(dev(a[10:8], 1'b1), a3);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
        ok = h & a3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic ok, ak, ak2;
        logic [7:0] b;
        clks(6);
        rst = 1'b0;
        clks(4);
        check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

        // table of byte writes (R3), each followed by the busy interval (R5)
        for (int i = 0; i < NV; i++) begin
            write_hdr(VEC[i][18:8], ok);
            send_byte(VEC[i][7:0], ak);
            bus_stop();
            check(ok & ak, "R3 write acks", ok & ak, 1);
            clks(BUSY + 100);
        end
        // random read-back of every entry (R7)
        for (int i = 0; i < NV; i++) begin
            rd_seq(VEC[i][18:8], 1, ok);
            check(ok, "R7 random read acks", ok, 1);
            check(rbuf[0] == VEC[i][7:0], "R7 random read data", rbuf[0], VEC[i][7:0]);
        end

        // R2 address decode
        bus_start(); send_byte(8'hD0, ak); bus_stop();
        check(!ak, "R2 A1 not inverted", ak, 0);
        bus_start(); send_byte(8'h70, ak); bus_stop();
        check(!ak, "R2 msb zero", ak, 0);
        check(sda_oe == 1'b0, "R1 idle after mismatch", sda_oe, 0);

        // R6: header-only write then stop, no busy
        write_hdr(11'h2B6, ok); bus_stop();
        bus_start(); send_byte(dev(3'd0, 1'b0), ak); bus_stop();
        check(ok & ak, "R6 no busy without data", ok & ak, 1);

        // R4 page wrap write at 0x3FC with six bytes
        write_hdr(11'h3FC, ok);
        for (int i = 0; i < 6; i++) begin
            send_byte(8'hA0 + 8'(i), ak);
            ok = ok & ak;
        end
        bus_stop();
        check(ok, "R3 page write acks", ok, 1);
        // R5 polling: deaf right away, responsive later
        bus_start(); send_byte(dev(3'd3, 1'b0), ak); bus_stop();
        check(!ak, "R5 no ack while busy", ak, 0);
        clks(BUSY + 100);
        bus_start(); send_byte(dev(3'd3, 1'b0), ak); bus_stop();
        check(ak, "R5 ack after busy", ak, 1);
        rd_seq(11'h3F0, 2, ok);
        check(rbuf[0] == 8'hA4, "R4 wrap byte 0x3F0", rbuf[0], 8'hA4);
        check(rbuf[1] == 8'hA5, "R4 wrap byte 0x3F1", rbuf[1], 8'hA5);
        rd_seq(11'h3FC, 4, ok);
        check(rbuf[0] == 8'hA0 && rbuf[3] == 8'hA3, "R4 page head/tail",
              {rbuf[0], rbuf[3]}, 16'hA0A3);

        // R7 current-address read: pointer now 0x400
        bus_start(); send_byte(dev(3'd4, 1'b1), ak);
        read_byte(1'b0, b); bus_stop();
        check(ak && b == 8'h5A, "R7 current address read", b, 8'h5A);

        // R8 sequential read across 2047 -> 0
        rd_seq(11'h7FF, 2, ok);
        check(rbuf[0] == 8'hC3, "R8 last byte", rbuf[0], 8'hC3);
        check(rbuf[1] == 8'h3C, "R8 wrap to zero", rbuf[1], 8'h3C);
        check(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);

        // R9 write protect
        wp = 1'b1;
        write_hdr(11'h123, ok); send_byte(8'hEE, ak); bus_stop();
        check(ok & ak, "R9 acks under protect", ok & ak, 1);
        clks(BUSY + 100);
        wp = 1'b0;
        rd_seq(11'h123, 1, ok);
        check(rbuf[0] == 8'h11, "R9 contents unchanged", rbuf[0], 8'h11);

        // R10 start in the middle of a data byte
        write_hdr(11'h055, ok);
        send_bits(8'h00, 4);
        bus_start(); send_byte(dev(3'd0, 1'b1), ak2);
        read_byte(1'b0, b); bus_stop();
        check(ak2, "R10 new address phase acked", ak2, 1);
        check(b == 8'h77, "R10 partial byte discarded", b, 8'h77);
        bus_start(); send_byte(dev(3'd0, 1'b0), ak); bus_stop();
        check(ak, "R10 no busy after abort", ak, 1);

        check(viol == 0, "R11 sda_oe only with SCL low", viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule